// File: doc/BRIEF.md
# E1 Alignment Loss Monitor

This block sits behind the bit-level aligner of an E1 receive path. It receives one strobe per checked item: each frame alignment word, each CAS multiframe alignment word and each CRC-4 codeword. The strobe carries an error flag. From these results it decides when each alignment level has been lost. Three separate rules apply. A CRC-4 loss is declared when 915 codewords within a running window of 1000 are bad. A frame alignment loss is declared after three bad alignment words in a row. A CAS multiframe loss is declared after two bad multiframe words in a row.

Each loss sets a sticky event bit and a "search active" status bit for its level. The search bit stays set until the aligner reports that it has found alignment again. A CRC-4 loss also puts the frame alignment search back online so that frame alignment is checked again. While the CRC-4 search runs, a 6-bit counter counts CRC-4 multiframes, and most of its bits can be read in the status byte.

The event byte also latches five event pulses that arrive from the elastic stores and the jitter attenuator. Software reads the event byte and clears it with a single strobe.

Top module: `e1_resync_monitor`

## Requirements
- R1: After synchronous reset, status_o is 0x07, with all three search bits set and the counter at zero, and event_o is 0x00.
- R2: When three strobed frame alignment words in a row are bad (fas_vld=1, fas_err=1), event_o bit 1 and status_o bit 2 are set in the cycle after the third. A good strobed word resets the run. Cycles with fas_vld=0 have no effect on the run.
- R3: When two strobed CAS multiframe words in a row are bad, event_o bit 0 and status_o bit 1 are set in the cycle after the second. A good word resets the run.
- R4: When the 915th bad CRC-4 codeword arrives within the current 1000-codeword window, event_o bit 2 is set, and so are status_o bit 0 (CRC-4 search) and bit 2 (frame alignment search). The bad-codeword tally then restarts from zero.
- R5: The bad-codeword tally restarts at each 1000-codeword window boundary. Windows of 914 bad codewords never raise the CRC-4 event.
- R6: The 6-bit CRC-4 sync counter increments on each crc_mf pulse while the CRC-4 search is active and saturates at 63. It shows in status_o[7:3] as counter bits {5,4,3,2,0}. Counter bit 1 is not visible.
- R7: A pulse on fas_found, cas_found or crc_found clears status_o bit 2, 1 or 0 respectively. A crc_found pulse also clears the counter.
- R8: Pulses on tx_full, tx_empty, jit_lim, rx_full and rx_empty set event_o bits 7, 6, 5, 4 and 3 respectively.
- R9: Event bits stay set until evt_clr is pulsed. evt_clr clears the whole byte, except that an event arriving in the same cycle stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fas_vld | input | 1 | Frame alignment word checked this cycle |
| fas_err | input | 1 | Checked frame alignment word was bad |
| cas_vld | input | 1 | CAS multiframe word checked this cycle |
| cas_err | input | 1 | Checked CAS multiframe word was bad |
| crc_vld | input | 1 | CRC-4 codeword checked this cycle |
| crc_err | input | 1 | Checked CRC-4 codeword was bad |
| crc_mf | input | 1 | CRC-4 multiframe boundary pulse |
| fas_found | input | 1 | Aligner regained frame alignment |
| cas_found | input | 1 | Aligner regained CAS multiframe alignment |
| crc_found | input | 1 | Aligner regained CRC-4 multiframe alignment |
| tx_full | input | 1 | Transmit store overflow event |
| tx_empty | input | 1 | Transmit store underflow event |
| jit_lim | input | 1 | Jitter attenuator near-limit event |
| rx_full | input | 1 | Receive store overflow event |
| rx_empty | input | 1 | Receive store underflow event |
| evt_clr | input | 1 | Read-to-clear strobe for event_o |
| status_o | output | 8 | {counter bits 5,4,3,2,0, FAS search, CAS search, CRC-4 search} |
| event_o | output | 8 | Sticky events, bit 7 down to bit 0 as in R8, R4, R2, R3 |

## Verification
The bench runs a full window of 914 bad codewords and checks that no event fires. A tally that skipped its reset at the window boundary would then fire early in the next window. In that next window it checks that the event fires on exactly the 915th bad codeword. It then sends 85 more bad codewords, which a tally left uncleared after the event would turn into a second event. The run detectors get unstrobed error cycles and a good word in mid-run, which catch a counter that counts unqualified errors or fails to restart. The sync counter is pushed past 63 to catch wrap-around, and the read clear is raised in the same cycle as a new event to catch a clear that takes priority over the set.

// File: rtl/e1rm_pkg.sv
package e1rm_pkg;
  localparam int ST_CRC = 0;
  localparam int ST_CAS = 1;
  localparam int ST_FAS = 2;
  localparam int EV_CAS = 0;
  localparam int EV_FAS = 1;
  localparam int EV_CRC = 2;
  localparam int EV_RXE = 3;
  localparam int EV_RXF = 4;
  localparam int EV_JIT = 5;
  localparam int EV_TXE = 6;
  localparam int EV_TXF = 7;
  typedef logic [7:0] reg8_t;
endpackage

// File: rtl/e1rm_run_det.sv
module e1rm_run_det #(
  parameter int RUN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic vld,
  input  logic err,
  output logic hit
);
  localparam int W = (RUN > 2) ? $clog2(RUN) : 1;
  localparam logic [W-1:0] LAST = W'(RUN - 1);

  logic [W-1:0] cnt_q;

  assign hit = vld && err && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (vld) begin
      if (!err || hit) cnt_q <= '0;
      else             cnt_q <= cnt_q + W'(1);
    end
  end

  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST); // R2, R3
  AST_RUN_RESTART: assert property (@(posedge clk) disable iff (rst)
    (vld && !err) |=> (cnt_q == '0)); // R2, R3
endmodule

// File: rtl/e1rm_crc_win.sv
module e1rm_crc_win #(
  parameter int WIN = 1000,
  parameter int THR = 915
) (
  input  logic clk,
  input  logic rst,
  input  logic vld,
  input  logic err,
  output logic hit
);
  localparam int WW = $clog2(WIN);
  localparam int TW = $clog2(THR);
  localparam logic [WW-1:0] WLAST = WW'(WIN - 1);
  localparam logic [TW-1:0] TLAST = TW'(THR - 1);

  logic [WW-1:0] wcnt_q;
  logic [TW-1:0] tally_q;
  logic          wrap;

  assign wrap = (wcnt_q == WLAST);
  assign hit  = vld && err && (tally_q == TLAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt_q  <= '0;
      tally_q <= '0;
    end else if (vld) begin
      wcnt_q  <= wrap ? '0 : wcnt_q + WW'(1);
      tally_q <= (wrap || hit) ? '0 : tally_q + TW'(err);
    end
  end

  AST_TALLY_BOUND: assert property (@(posedge clk) disable iff (rst)
    tally_q <= TLAST); // R4
  AST_WIN_WRAP: assert property (@(posedge clk) disable iff (rst)
    (vld && wrap) |=> (wcnt_q == '0 && tally_q == '0)); // R5
  AST_HIT_RESTART: assert property (@(posedge clk) disable iff (rst)
    hit |=> (tally_q == '0)); // R4
endmodule

// File: rtl/e1rm_sync_stat.sv
module e1rm_sync_stat #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fas_evt,
  input  logic          cas_evt,
  input  logic          crc_evt,
  input  logic          fas_found,
  input  logic          cas_found,
  input  logic          crc_found,
  input  logic          crc_mf,
  output logic          fas_srch,
  output logic          cas_srch,
  output logic          crc_srch,
  output logic [CW-1:0] sync_cnt
);
  localparam logic [CW-1:0] CMAX = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      fas_srch <= 1'b1;
      cas_srch <= 1'b1;
      crc_srch <= 1'b1;
      sync_cnt <= '0;
    end else begin
      if (fas_evt || crc_evt) fas_srch <= 1'b1;
      else if (fas_found)     fas_srch <= 1'b0;
      if (cas_evt)            cas_srch <= 1'b1;
      else if (cas_found)     cas_srch <= 1'b0;
      if (crc_evt)            crc_srch <= 1'b1;
      else if (crc_found)     crc_srch <= 1'b0;
      if (crc_found && !crc_evt)
        sync_cnt <= '0;
      else if (crc_mf && crc_srch && sync_cnt != CMAX)
        sync_cnt <= sync_cnt + CW'(1);
    end
  end

  AST_CNT_SAT: assert property (@(posedge clk) disable iff (rst)
    (sync_cnt == CMAX && !crc_found) |=> (sync_cnt == CMAX)); // R6
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!crc_srch && !crc_evt && !crc_found) |=> $stable(sync_cnt)); // R6
  AST_FOUND_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (crc_found && !crc_evt) |=> (!crc_srch && sync_cnt == '0)); // R7
  AST_CRC_REARMS_FAS: assert property (@(posedge clk) disable iff (rst)
    crc_evt |=> (fas_srch && crc_srch)); // R4
endmodule

// File: rtl/e1_resync_monitor.sv
module e1_resync_monitor #(
  parameter int FAS_RUN = 3,
  parameter int CAS_RUN = 2,
  parameter int CRC_WIN = 1000,
  parameter int CRC_THR = 915,
  parameter int CNT_W   = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       fas_vld,
  input  logic       fas_err,
  input  logic       cas_vld,
  input  logic       cas_err,
  input  logic       crc_vld,
  input  logic       crc_err,
  input  logic       crc_mf,
  input  logic       fas_found,
  input  logic       cas_found,
  input  logic       crc_found,
  input  logic       tx_full,
  input  logic       tx_empty,
  input  logic       jit_lim,
  input  logic       rx_full,
  input  logic       rx_empty,
  input  logic       evt_clr,
  output logic [7:0] status_o,
  output logic [7:0] event_o
);
  import e1rm_pkg::*;

  logic fas_hit, cas_hit, crc_hit;
  logic fas_srch, cas_srch, crc_srch;
  logic [CNT_W-1:0] sync_cnt;
  reg8_t new_ev;
  reg8_t ev_q;

  e1rm_run_det #(.RUN(FAS_RUN)) u_fas (
    .clk(clk), .rst(rst), .vld(fas_vld), .err(fas_err), .hit(fas_hit));

  e1rm_run_det #(.RUN(CAS_RUN)) u_cas (
    .clk(clk), .rst(rst), .vld(cas_vld), .err(cas_err), .hit(cas_hit));

  e1rm_crc_win #(.WIN(CRC_WIN), .THR(CRC_THR)) u_crc (
    .clk(clk), .rst(rst), .vld(crc_vld), .err(crc_err), .hit(crc_hit));

  e1rm_sync_stat #(.CW(CNT_W)) u_stat (
    .clk(clk), .rst(rst),
    .fas_evt(fas_hit), .cas_evt(cas_hit), .crc_evt(crc_hit),
    .fas_found(fas_found), .cas_found(cas_found), .crc_found(crc_found),
    .crc_mf(crc_mf),
    .fas_srch(fas_srch), .cas_srch(cas_srch), .crc_srch(crc_srch),
    .sync_cnt(sync_cnt));

  always_comb begin
    new_ev         = '0;
    new_ev[EV_TXF] = tx_full;
    new_ev[EV_TXE] = tx_empty;
    new_ev[EV_JIT] = jit_lim;
    new_ev[EV_RXF] = rx_full;
    new_ev[EV_RXE] = rx_empty;
    new_ev[EV_CRC] = crc_hit;
    new_ev[EV_FAS] = fas_hit;
    new_ev[EV_CAS] = cas_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) ev_q <= '0;
    else     ev_q <= (evt_clr ? '0 : ev_q) | new_ev;
  end

  assign event_o = ev_q;
  assign status_o = {sync_cnt[5], sync_cnt[4], sync_cnt[3], sync_cnt[2],
                     sync_cnt[0], fas_srch, cas_srch, crc_srch};

  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (rst)
    !evt_clr |=> ((event_o & $past(event_o)) == $past(event_o))); // R9
  AST_CLR_KEEPS_NEW: assert property (@(posedge clk) disable iff (rst)
    evt_clr |=> (event_o == $past(new_ev))); // R9
  AST_FAS_EVT_SRCH: assert property (@(posedge clk) disable iff (rst)
    fas_hit |=> (event_o[EV_FAS] && status_o[ST_FAS])); // R2
  AST_CAS_EVT_SRCH: assert property (@(posedge clk) disable iff (rst)
    cas_hit |=> (event_o[EV_CAS] && status_o[ST_CAS])); // R3
endmodule

// File: tb/sim_e1_resync_monitor.sv
module sim_e1_resync_monitor;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst;
  logic fas_vld, fas_err, cas_vld, cas_err, crc_vld, crc_err, crc_mf;
  logic fas_found, cas_found, crc_found;
  logic tx_full, tx_empty, jit_lim, rx_full, rx_empty, evt_clr;
  logic [7:0] status_o, event_o;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  e1_resync_monitor u0 (
    .clk(clk), .rst(rst),
    .fas_vld(fas_vld), .fas_err(fas_err), .cas_vld(cas_vld), .cas_err(cas_err),
    .crc_vld(crc_vld), .crc_err(crc_err), .crc_mf(crc_mf),
    .fas_found(fas_found), .cas_found(cas_found), .crc_found(crc_found),
    .tx_full(tx_full), .tx_empty(tx_empty), .jit_lim(jit_lim),
    .rx_full(rx_full), .rx_empty(rx_empty), .evt_clr(evt_clr),
    .status_o(status_o), .event_o(event_o));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic idle_all();
    {fas_vld, fas_err, cas_vld, cas_err, crc_vld, crc_err, crc_mf} = '0;
    {fas_found, cas_found, crc_found} = '0;
    {tx_full, tx_empty, jit_lim, rx_full, rx_empty, evt_clr} = '0;
  endtask

  // Inputs change at the falling edge; outputs are read just after the rising edge.
  task automatic step();
    @(posedge clk);
    #1;
    idle_all();
  endtask

  task automatic fas_word(input logic v, input logic e);
    @(negedge clk); fas_vld = v; fas_err = e; step();
  endtask

  task automatic cas_word(input logic e);
    @(negedge clk); cas_vld = 1'b1; cas_err = e; step();
  endtask

  task automatic crc_word(input logic e);
    @(negedge clk); crc_vld = 1'b1; crc_err = e; step();
  endtask

  task automatic mf_pulse();
    @(negedge clk); crc_mf = 1'b1; step();
  endtask

  task automatic clear_ev();
    @(negedge clk); evt_clr = 1'b1; step();
  endtask

  function automatic logic [4:0] vis(input int c);
    logic [5:0] v;
    v = 6'(c);
    return {v[5], v[4], v[3], v[2], v[0]};
  endfunction

  task automatic t_reset();
    rst = 1'b1; idle_all();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R1 status", status_o, 8'h07);
    chk("R1 event", event_o, 8'h00);
  endtask

  task automatic t_found();
    @(negedge clk); fas_found = 1'b1; step();
    chk("R7 fas_found", status_o, 8'h03);
    @(negedge clk); cas_found = 1'b1; step();
    chk("R7 cas_found", status_o, 8'h01);
    @(negedge clk); crc_found = 1'b1; step();
    chk("R7 crc_found", status_o, 8'h00);
  endtask

  task automatic t_crc_window();
    for (int i = 0; i < 914; i++) crc_word(1'b1);
    for (int i = 0; i < 86; i++) crc_word(1'b0);
    chk("R5 914 of window 1", event_o, 8'h00);
    for (int i = 0; i < 914; i++) crc_word(1'b1);
    chk("R5 914 after boundary", event_o, 8'h00);
    crc_word(1'b1);
    chk("R4 event on 915th", event_o, 8'h04);
    chk("R4 crc and fas search", status_o, 8'h05);
    clear_ev();
    for (int i = 0; i < 85; i++) crc_word(1'b1);
    chk("R4 tally restarted", event_o, 8'h00);
  endtask

  task automatic t_counter();
    for (int i = 0; i < 5; i++) mf_pulse();
    chk("R6 count 5", status_o, {vis(5), 3'b101});
    for (int i = 0; i < 2; i++) mf_pulse();
    chk("R6 count 7", status_o, {vis(7), 3'b101});
    for (int i = 0; i < 70; i++) mf_pulse();
    chk("R6 saturate 63", status_o, {vis(63), 3'b101});
    @(negedge clk); crc_found = 1'b1; fas_found = 1'b1; step();
    chk("R7 counter cleared", status_o, 8'h00);
    for (int i = 0; i < 3; i++) mf_pulse();
    chk("R6 no count idle", status_o, 8'h00);
  endtask

  task automatic t_fas();
    fas_word(1'b1, 1'b1); fas_word(1'b1, 1'b1); fas_word(1'b1, 1'b0);
    fas_word(1'b1, 1'b1); fas_word(1'b0, 1'b1); fas_word(1'b1, 1'b1);
    chk("R2 run broken", event_o, 8'h00);
    fas_word(1'b1, 1'b1);
    chk("R2 event", event_o, 8'h02);
    chk("R2 search", status_o, 8'h04);
    fas_word(1'b1, 1'b0);
    chk("R9 sticky after good", event_o, 8'h02);
    clear_ev();
    chk("R9 cleared", event_o, 8'h00);
    chk("R2 search holds", status_o, 8'h04);
    @(negedge clk); fas_found = 1'b1; step();
  endtask

  task automatic t_cas();
    cas_word(1'b1); cas_word(1'b0); cas_word(1'b1);
    chk("R3 run broken", event_o, 8'h00);
    cas_word(1'b1);
    chk("R3 event", event_o, 8'h01);
    chk("R3 search", status_o, 8'h02);
    clear_ev();
    @(negedge clk); cas_found = 1'b1; step();
  endtask

  task automatic t_pass();
    @(negedge clk); tx_full = 1'b1; step();  chk("R8 tx_full", event_o, 8'h80); clear_ev();
    @(negedge clk); tx_empty = 1'b1; step(); chk("R8 tx_empty", event_o, 8'h40); clear_ev();
    @(negedge clk); jit_lim = 1'b1; step();  chk("R8 jit_lim", event_o, 8'h20); clear_ev();
    @(negedge clk); rx_full = 1'b1; step();  chk("R8 rx_full", event_o, 8'h10); clear_ev();
    @(negedge clk); rx_empty = 1'b1; step(); chk("R8 rx_empty", event_o, 8'h08); clear_ev();
  endtask

  task automatic t_sticky();
    @(negedge clk); tx_empty = 1'b1; step();
    repeat (4) @(posedge clk);
    #1;
    chk("R9 held", event_o, 8'h40);
    @(negedge clk); evt_clr = 1'b1; rx_full = 1'b1; step();
    chk("R9 set beats clear", event_o, 8'h10);
    cas_word(1'b1);
    @(negedge clk); evt_clr = 1'b1; cas_vld = 1'b1; cas_err = 1'b1; step();
    chk("R9 run event beats clear", event_o, 8'h01);
    clear_ev();
    chk("R9 final clear", event_o, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_found();
    t_crc_window();
    t_counter();
    t_fas();
    t_cas();
    t_pass();
    t_sticky();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule